// File: doc/BRIEF.md
# Triggered SPI Program Replay Sequencer

The sequencer keeps a short SPI command program and a set of fixed transmit words in two local memories. Software fills each memory by writing words one after another to that memory's load port. After that, every external trigger that arrives while the unit is enabled plays the whole program out again to a command-driven SPI core. The program goes out on a valid/ready command stream and the transmit words go out on a valid/ready data stream. No processor action is needed for each transaction.

A clear input empties both memories and drops the error flags, so that a new program can be loaded. A capability word reports the base-2 logarithm of each memory depth. A build option removes the transmit memory for designs where transmit data is streamed from elsewhere. In that build the capability field for the transmit memory reads zero and the data stream stays idle.

Top module: `trig_replay_seq`

## Requirements
- R1: `caps[7:0]` holds the command memory address width and `caps[15:8]` holds the transmit memory address width. The field for the transmit memory is 0 when that memory is not built. With the defaults (16 entries each), `caps` = 16'h0404.
- R2: A trigger is sampled at a clock edge when `ctrl_enable`=1, the unit is idle and the command memory is not empty. After that edge `busy`=1 and `cmd_out_valid`=1. Entry 0 is offered first, and the remaining loaded entries follow in load order, one per accepted handshake. `busy` and `cmd_out_valid` are 0 from the edge that accepts the last loaded entry.
- R3: A load write made when a memory already holds 16 entries is dropped, and the sticky `overflow` output becomes 1 at the next edge. Entries already stored are unchanged.
- R4: While `ctrl_enable`=0, a trigger from idle starts no replay: `busy` and `cmd_out_valid` stay 0.
- R5: A trigger that arrives while `busy`=1 does not restart or extend the replay. It sets the sticky `overrun` output to 1.
- R6: Holding `ctrl_clear` high for one cycle does three things: it empties both memories, it returns the unit to idle, and it clears `overrun` and `overflow`. A trigger after that starts no replay until a command is loaded.
- R7: During a replay, the stored transmit words are offered on `tx_out_*` in load order, starting at entry 0. The data pointer advances only on a `tx_out_valid`&&`tx_out_ready` handshake. `tx_out_valid` is 1 only while `busy`=1 and unsent words remain, so an empty transmit memory gives no data.
- R8: A stored command whose bits 15:12 are 4'h3 and whose bits 11:8 are 4'h0 is a sync instruction. It is emitted with bits 7:0 forced to 8'h00. Every other command is emitted unchanged.
- R9: A replay leaves both memories unchanged, so a later trigger produces the identical command and data sequence.
- R10: While `cmd_out_valid`=1 and `cmd_out_ready`=0, the command stream holds its valid and its word.
- R11: After reset, `busy`, `cmd_out_valid`, `tx_out_valid`, `overrun` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_enable | input | 1 | Lets triggers start a replay |
| ctrl_clear | input | 1 | Empties both memories and clears the flags |
| trigger | input | 1 | Replay request, sampled each edge |
| cmd_load_valid | input | 1 | Appends `cmd_load_word` to the command memory |
| cmd_load_word | input | 16 | Command word to store |
| dat_load_valid | input | 1 | Appends `dat_load_word` to the transmit memory |
| dat_load_word | input | DAT_W | Transmit word to store |
| cmd_out_valid | output | 1 | Command offered to the SPI core |
| cmd_out_ready | input | 1 | SPI core accepts the command |
| cmd_out_word | output | 16 | Replayed command |
| tx_out_valid | output | 1 | Transmit word offered to the SPI core |
| tx_out_ready | input | 1 | SPI core accepts the transmit word |
| tx_out_word | output | DAT_W | Replayed transmit word |
| busy | output | 1 | Replay in progress |
| overrun | output | 1 | Sticky: trigger arrived during a replay |
| overflow | output | 1 | Sticky: load write dropped because a memory was full |
| caps | output | 16 | Memory size capability word |

## Verification
A trigger or a load write takes effect at the edge that samples it. `busy`, the first command word, `overflow` and `overrun` are therefore all due one edge later. Each stream advances one entry per handshake edge. The bench changes inputs and reads outputs only at falling edges. A pulse started at one falling edge is checked at the next falling edge. During a replay the bench records one command and one data word at each falling edge where valid and ready are both high, which matches the word the next rising edge consumes. In stalled cycles the bench checks that entry 0 is still offered, and once `busy` drops it compares the recorded sequences and their lengths with the loaded program.

// File: rtl/trs_pkg.sv
package trs_pkg;
    localparam int CMD_W = 16;
    localparam logic [3:0] OP_MISC  = 4'h3;
    localparam logic [3:0] SUB_SYNC = 4'h0;

    typedef enum logic {ST_IDLE, ST_RUN} trs_state_e;

    // Replayed sync instructions always report ID 0.
    function automatic logic [CMD_W-1:0] scrub_sync(input logic [CMD_W-1:0] w);
        if (w[15:12] == OP_MISC && w[11:8] == SUB_SYNC)
            return {w[15:8], 8'h00};
        return w;
    endfunction
endpackage

// File: rtl/trs_mem.sv
module trs_mem #(
    parameter int AW = 4,
    parameter int W  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic [AW:0]   fill,
    output logic          drop
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    logic [W-1:0] store_q [DEPTH];
    logic [AW:0]  fill_d, fill_q;
    logic         full;

    assign full = (fill_q == FULL);
    assign drop = wr_en && !clear && full;

    always_comb begin
        fill_d = fill_q;
        if (clear)
            fill_d = '0;
        else if (wr_en && !full)
            fill_d = fill_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clear && !full)
            store_q[fill_q[AW-1:0]] <= wr_data;
    end

    assign rd_data = store_q[rd_addr];
    assign fill    = fill_q;

    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FULL);
    p_drop_keeps_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> $stable(fill_q));
endmodule

// File: rtl/trs_replay.sv
module trs_replay
    import trs_pkg::*;
#(
    parameter int CAW     = 4,
    parameter int DAW     = 4,
    parameter int DW      = 32,
    parameter bit HAS_DAT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clear,
    input  logic             trigger,
    input  logic [CAW:0]     cmd_fill,
    input  logic [DAW:0]     dat_fill,
    input  logic [CMD_W-1:0] cmd_rd_data,
    input  logic [DW-1:0]    dat_rd_data,
    output logic [CAW-1:0]   cmd_rd_addr,
    output logic [DAW-1:0]   dat_rd_addr,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [CMD_W-1:0] cmd_word,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [DW-1:0]    tx_word,
    output logic             busy,
    output logic             overrun
);
    typedef struct packed {
        trs_state_e   st;
        logic [CAW:0] cptr;
        logic [DAW:0] dptr;
        logic         ovr;
    } rep_t;

    rep_t r_d, r_q;

    assign cmd_valid   = (r_q.st == ST_RUN);
    assign tx_valid    = HAS_DAT && (r_q.st == ST_RUN) && (r_q.dptr < dat_fill);
    assign cmd_rd_addr = r_q.cptr[CAW-1:0];
    assign dat_rd_addr = r_q.dptr[DAW-1:0];
    assign cmd_word    = scrub_sync(cmd_rd_data);
    assign tx_word     = dat_rd_data;
    assign busy        = (r_q.st == ST_RUN);
    assign overrun     = r_q.ovr;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.st   = ST_IDLE;
            r_d.cptr = '0;
            r_d.dptr = '0;
            r_d.ovr  = 1'b0;
        end else if (r_q.st == ST_IDLE) begin
            if (trigger && enable && cmd_fill != '0) begin
                r_d.st   = ST_RUN;
                r_d.cptr = '0;
                r_d.dptr = '0;
            end
        end else begin
            if (trigger)
                r_d.ovr = 1'b1;
            if (tx_valid && tx_ready)
                r_d.dptr = r_q.dptr + 1'b1;
            if (cmd_ready) begin
                if (r_q.cptr + 1'b1 == cmd_fill)
                    r_d.st = ST_IDLE;
                else
                    r_d.cptr = r_q.cptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, cptr: '0, dptr: '0, ovr: 1'b0};
        else        r_q <= r_d;
    end

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !clear) |=> (cmd_valid && $stable(cmd_word)));
    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clear) |=> overrun);
    p_disabled_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !enable) |=> !busy);
    p_tx_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);
endmodule

// File: rtl/trig_replay_seq.sv
module trig_replay_seq
    import trs_pkg::*;
#(
    parameter int CMD_AW    = 4,
    parameter int DAT_AW    = 4,
    parameter int DAT_W     = 32,
    parameter bit STREAM_TX = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_enable,
    input  logic             ctrl_clear,
    input  logic             trigger,
    input  logic             cmd_load_valid,
    input  logic [CMD_W-1:0] cmd_load_word,
    input  logic             dat_load_valid,
    input  logic [DAT_W-1:0] dat_load_word,
    output logic             cmd_out_valid,
    input  logic             cmd_out_ready,
    output logic [CMD_W-1:0] cmd_out_word,
    output logic             tx_out_valid,
    input  logic             tx_out_ready,
    output logic [DAT_W-1:0] tx_out_word,
    output logic             busy,
    output logic             overrun,
    output logic             overflow,
    output logic [15:0]      caps
);
    localparam logic [7:0] CMD_LOG = 8'(CMD_AW);
    localparam logic [7:0] DAT_LOG = STREAM_TX ? 8'd0 : 8'(DAT_AW);

    logic [CMD_AW:0]    cmd_fill;
    logic [DAT_AW:0]    dat_fill;
    logic [CMD_AW-1:0]  cmd_rd_addr;
    logic [DAT_AW-1:0]  dat_rd_addr;
    logic [CMD_W-1:0]   cmd_rd_data;
    logic [DAT_W-1:0]   dat_rd_data;
    logic               cmd_drop, dat_drop;
    logic               ovf_d, ovf_q;

    assign caps = {DAT_LOG, CMD_LOG};

    trs_mem #(.AW(CMD_AW), .W(CMD_W)) u_cmd_mem (
        .clk(clk), .rst_n(rst_n), .clear(ctrl_clear),
        .wr_en(cmd_load_valid), .wr_data(cmd_load_word),
        .rd_addr(cmd_rd_addr), .rd_data(cmd_rd_data),
        .fill(cmd_fill), .drop(cmd_drop)
    );

    generate
        if (!STREAM_TX) begin : g_dat_mem
            trs_mem #(.AW(DAT_AW), .W(DAT_W)) u_dat_mem (
                .clk(clk), .rst_n(rst_n), .clear(ctrl_clear),
                .wr_en(dat_load_valid), .wr_data(dat_load_word),
                .rd_addr(dat_rd_addr), .rd_data(dat_rd_data),
                .fill(dat_fill), .drop(dat_drop)
            );
        end else begin : g_no_dat
            assign dat_fill    = '0;
            assign dat_rd_data = '0;
            assign dat_drop    = 1'b0;
        end
    endgenerate

    trs_replay #(.CAW(CMD_AW), .DAW(DAT_AW), .DW(DAT_W), .HAS_DAT(!STREAM_TX)) u_replay (
        .clk(clk), .rst_n(rst_n), .enable(ctrl_enable), .clear(ctrl_clear),
        .trigger(trigger), .cmd_fill(cmd_fill), .dat_fill(dat_fill),
        .cmd_rd_data(cmd_rd_data), .dat_rd_data(dat_rd_data),
        .cmd_rd_addr(cmd_rd_addr), .dat_rd_addr(dat_rd_addr),
        .cmd_valid(cmd_out_valid), .cmd_ready(cmd_out_ready), .cmd_word(cmd_out_word),
        .tx_valid(tx_out_valid), .tx_ready(tx_out_ready), .tx_word(tx_out_word),
        .busy(busy), .overrun(overrun)
    );

    always_comb begin
        ovf_d = ovf_q;
        if (ctrl_clear)
            ovf_d = 1'b0;
        else if (cmd_drop || dat_drop)
            ovf_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_d;
    end

    assign overflow = ovf_q;

    p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ctrl_clear) |=> overflow);
    p_clear_idles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_clear |=> (!busy && !overrun && !overflow));
endmodule

// File: tb/trig_replay_seq_bench.sv
module trig_replay_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_enable = 1'b0, ctrl_clear = 1'b0, trigger = 1'b0;
    logic        cmd_load_valid = 1'b0, dat_load_valid = 1'b0;
    logic [15:0] cmd_load_word = '0;
    logic [31:0] dat_load_word = '0;
    logic        cmd_out_valid, tx_out_valid, busy, overrun, overflow;
    logic        cmd_out_ready = 1'b1, tx_out_ready = 1'b1;
    logic [15:0] cmd_out_word, caps;
    logic [31:0] tx_out_word;

    int checks = 0, failures = 0;
    logic [15:0] exp_cmd [32];
    logic [31:0] exp_dat [32];
    int n_exp_cmd = 0, n_exp_dat = 0;
    logic [15:0] got_cmd [64];
    logic [31:0] got_dat [64];
    int n_cmd, n_dat;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_replay_seq u_trig_replay_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .ctrl_clear(ctrl_clear),
        .trigger(trigger), .cmd_load_valid(cmd_load_valid), .cmd_load_word(cmd_load_word),
        .dat_load_valid(dat_load_valid), .dat_load_word(dat_load_word),
        .cmd_out_valid(cmd_out_valid), .cmd_out_ready(cmd_out_ready), .cmd_out_word(cmd_out_word),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_word(tx_out_word),
        .busy(busy), .overrun(overrun), .overflow(overflow), .caps(caps)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sync_fix(input logic [15:0] w);
        return (w[15:8] == 8'h30) ? {w[15:8], 8'h00} : w;
    endfunction

    task automatic load_cmd(input logic [15:0] w);
        cmd_load_valid = 1'b1; cmd_load_word = w;
        @(negedge clk);
        cmd_load_valid = 1'b0;
        exp_cmd[n_exp_cmd % 32] = sync_fix(w);
        n_exp_cmd++;
    endtask

    task automatic load_dat(input logic [31:0] w);
        dat_load_valid = 1'b1; dat_load_word = w;
        @(negedge clk);
        dat_load_valid = 1'b0;
        exp_dat[n_exp_dat] = w;
        n_exp_dat++;
    endtask

    task automatic fire();
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
    endtask

    task automatic pulse_clear();
        ctrl_clear = 1'b1;
        @(negedge clk);
        ctrl_clear = 1'b0;
        n_exp_cmd = 0; n_exp_dat = 0;
    endtask

    // Records both streams until busy drops; checks order and lengths.
    task automatic capture(input int cmd_hold, input int tx_hold, input int inject_at, input string tag);
        int exp_tx;
        n_cmd = 0; n_dat = 0;
        for (int it = 0; it < 300; it++) begin
            if (!busy) break;
            cmd_out_ready = (it >= cmd_hold);
            tx_out_ready  = (it >= tx_hold);
            trigger       = (it == inject_at);
            if (it < cmd_hold)
                chk(cmd_out_valid && cmd_out_word == exp_cmd[0], "R10 stall hold", cmd_out_word, exp_cmd[0]);
            if (it < tx_hold && n_exp_dat > 0)
                chk(tx_out_valid && tx_out_word == exp_dat[0], "R7 data held", tx_out_word, exp_dat[0]);
            if (cmd_out_valid && cmd_out_ready) begin got_cmd[n_cmd] = cmd_out_word; n_cmd++; end
            if (tx_out_valid && tx_out_ready) begin got_dat[n_dat] = tx_out_word; n_dat++; end
            @(negedge clk);
        end
        cmd_out_ready = 1'b1; tx_out_ready = 1'b1; trigger = 1'b0;
        chk(n_cmd == n_exp_cmd, {tag, " R2 cmd count"}, n_cmd, n_exp_cmd);
        for (int i = 0; i < n_cmd && i < n_exp_cmd; i++)
            chk(got_cmd[i] == exp_cmd[i], {tag, " R2 cmd word"}, got_cmd[i], exp_cmd[i]);
        exp_tx = n_exp_cmd + cmd_hold - tx_hold;
        if (exp_tx > n_exp_dat) exp_tx = n_exp_dat;
        if (exp_tx < 0) exp_tx = 0;
        chk(n_dat == exp_tx, {tag, " R7 data count"}, n_dat, exp_tx);
        for (int i = 0; i < n_dat && i < n_exp_dat; i++)
            chk(got_dat[i] == exp_dat[i], {tag, " R7 data word"}, got_dat[i], exp_dat[i]);
        chk(!busy && !cmd_out_valid && !tx_out_valid, {tag, " R2 idle after"}, busy, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !cmd_out_valid && !tx_out_valid, "R11 idle after reset", {busy, cmd_out_valid, tx_out_valid}, 0);
        chk(!overrun && !overflow, "R11 flags after reset", {overrun, overflow}, 0);
        chk(caps == 16'h0404, "R1 caps", caps, 16'h0404);
    endtask

    task automatic t_load_and_disabled();
        load_cmd(16'h2101); load_cmd(16'h1080); load_cmd(16'h0103);
        load_cmd(16'h3005); load_cmd(16'h3104); load_cmd(16'h01FF);
        load_dat(32'hA5A5_0001); load_dat(32'h5A5A_0002);
        load_dat(32'hDEAD_0003); load_dat(32'hBEEF_0004);
        ctrl_enable = 1'b0;
        fire();
        chk(!busy && !cmd_out_valid, "R4 disabled trigger ignored", busy, 0);
        @(negedge clk);
        chk(!busy && !cmd_out_valid, "R4 still idle", busy, 0);
    endtask

    task automatic t_basic();
        ctrl_enable = 1'b1;
        fire();
        chk(busy && cmd_out_valid && cmd_out_word == exp_cmd[0], "R2 start at entry 0", cmd_out_word, exp_cmd[0]);
        chk(exp_cmd[3] == 16'h3000, "R8 expected sync id zero", exp_cmd[3], 16'h3000);
        capture(0, 2, -1, "basic R8");
    endtask

    task automatic t_repeat();
        fire();
        capture(0, 0, -1, "repeat R9");
    endtask

    task automatic t_stall();
        fire();
        capture(3, 0, -1, "stall R10");
    endtask

    task automatic t_overrun();
        chk(!overrun, "R5 overrun clear before", overrun, 0);
        fire();
        capture(0, 0, 2, "overrun R5");
        chk(overrun, "R5 overrun set", overrun, 1);
        @(negedge clk);
        chk(!busy, "R5 no restart", busy, 0);
    endtask

    task automatic t_clear_and_overflow();
        pulse_clear();
        chk(!overrun && !overflow, "R6 flags cleared", {overrun, overflow}, 0);
        fire();
        chk(!busy && !cmd_out_valid, "R6 empty memory gives no replay", busy, 0);
        for (int i = 0; i < 16; i++) load_cmd(16'h1000 + 16'(i));
        chk(!overflow, "R3 no overflow at depth", overflow, 0);
        cmd_load_valid = 1'b1; cmd_load_word = 16'h7777;
        @(negedge clk);
        cmd_load_valid = 1'b0;
        chk(overflow, "R3 overflow on extra write", overflow, 1);
        fire();
        capture(0, 0, -1, "overflow R3");
        chk(got_cmd[15] == 16'h100F, "R3 last entry kept", got_cmd[15], 16'h100F);
        pulse_clear();
        chk(!overflow, "R6 overflow cleared", overflow, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_and_disabled();
        t_basic();
        t_repeat();
        t_stall();
        t_overrun();
        t_clear_and_overflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule